// File: doc/BRIEF.md
# Shared-Adder Sixteen-Bit ALU

This block is a purely combinational arithmetic and logic unit. It takes two 16-bit operands and a 4-bit operation code, and it returns a 16-bit result with carry, zero and overflow flags. A single ripple adder produces almost every result. A small decoder sets how the adder's inputs are formed: the first input can be A, the inverse of A, or zero. The second input can be B, the inverse of B, zero, all ones, or A. The decoder also sets a forced carry-in and a carry-kill control that cuts the carry chain.

When the carry chain is killed, each bit position becomes a single gate. The sum bit gives XOR, the per-bit generate term gives AND, and generate OR propagate gives OR. A 16-entry output selector, indexed by the operation code, picks the final result. Codes that are not assigned give a zero result.

The unit is meant to sit in the execute stage of a small datapath. It has no clock. The surrounding pipeline registers its outputs.

Top module: `alu_shared`

## Requirements
- R1: Code 0 (add) returns A+B modulo 2^16. Carry is the carry-out of bit 15. Overflow is set when A and B have the same sign bit and the result's sign bit differs from it.
- R2: Code 1 (subtract) returns A-B modulo 2^16. Carry is 1 exactly when A >= B as unsigned numbers, meaning no borrow. Overflow is set when A and B differ in sign and the result's sign differs from A.
- R3: Code 2 (negate) returns the two's complement of A. Carry is 1 only when A = 0x0000. Overflow is 1 only when A = 0x8000.
- R4: Code 3 (invert) returns the bitwise complement of A, with carry and overflow both 0.
- R5: Code 4 (increment) returns A+1, with carry only for A = 0xFFFF and overflow only for A = 0x7FFF. Code 5 (decrement) returns A-1, with carry set for every A except 0x0000 and overflow only for A = 0x8000.
- R6: Code 6 (shift left) returns A shifted left by one with a 0 entering bit 0. Carry equals A bit 15. Overflow is set when A bit 15 differs from A bit 14.
- R7: Codes 7, 8 and 9 return A AND B, A OR B and A XOR B respectively, with carry and overflow both 0.
- R8: Code 10 returns A unchanged and code 11 returns B unchanged, with carry and overflow both 0.
- R9: Codes 12 to 15 return 0x0000 with carry and overflow both 0, whatever the operands are.
- R10: For every code, the zero flag is 1 exactly when the 16-bit result is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 to 15) |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Selected result |
| flag_carry | output | 1 | Adder carry-out (0 for killed-carry codes) |
| flag_zero | output | 1 | Result is all zeros |
| flag_ovf | output | 1 | Signed overflow of the adder (0 for killed-carry codes) |

## Verification
Two flag events can rise together in the same evaluation: carry with signed overflow, and carry with zero. The bench provokes the first with 0x8000 - 0x0001 and with 0x8000 + 0x8000. It provokes the second with 0xFFFF + 1, increment of 0xFFFF and negate of 0x0000. In each case all three flags and the result are compared as one vector against a reference model. That model computes the answer from wide integer arithmetic, not from the inversion and carry-in scheme. Every code is then swept across the boundary operands 0, 1, 0x7FFF, 0x8000 and 0xFFFF on both inputs, followed by pseudo-random operands.

// File: rtl/alu_shared_pkg.sv
package alu_shared_pkg;
  localparam int OP_W  = 4;
  localparam int N_OPS = 1 << OP_W;

  localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd1;
  localparam logic [OP_W-1:0] OP_NEG   = 4'd2;
  localparam logic [OP_W-1:0] OP_NOT   = 4'd3;
  localparam logic [OP_W-1:0] OP_INC   = 4'd4;
  localparam logic [OP_W-1:0] OP_DEC   = 4'd5;
  localparam logic [OP_W-1:0] OP_SHL   = 4'd6;
  localparam logic [OP_W-1:0] OP_AND   = 4'd7;
  localparam logic [OP_W-1:0] OP_OR    = 4'd8;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd9;
  localparam logic [OP_W-1:0] OP_PASSA = 4'd10;
  localparam logic [OP_W-1:0] OP_PASSB = 4'd11;

  // source of the adder's first input
  typedef enum logic [1:0] {XS_A, XS_NA, XS_ZERO} xsel_e;
  // source of the adder's second input
  typedef enum logic [2:0] {YS_B, YS_NB, YS_ZERO, YS_ONES, YS_A} ysel_e;

  typedef struct packed {
    xsel_e xs;
    ysel_e ys;
    logic  cin;
    logic  kill;
  } adder_ctl_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_shared_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output adder_ctl_t      ctl
);
  always_comb begin
    // unassigned codes: both inputs zero, chain cut -> zero result, no flags
    ctl.xs   = XS_ZERO;
    ctl.ys   = YS_ZERO;
    ctl.cin  = 1'b0;
    ctl.kill = 1'b1;
    unique case (op)
      OP_ADD:   begin ctl.xs = XS_A;    ctl.ys = YS_B;    ctl.kill = 1'b0; end
      OP_SUB:   begin ctl.xs = XS_A;    ctl.ys = YS_NB;   ctl.kill = 1'b0; ctl.cin = 1'b1; end
      OP_NEG:   begin ctl.xs = XS_NA;   ctl.ys = YS_ZERO; ctl.kill = 1'b0; ctl.cin = 1'b1; end
      OP_NOT:   begin ctl.xs = XS_NA;   ctl.ys = YS_ZERO; ctl.kill = 1'b1; end
      OP_INC:   begin ctl.xs = XS_A;    ctl.ys = YS_ZERO; ctl.kill = 1'b0; ctl.cin = 1'b1; end
      OP_DEC:   begin ctl.xs = XS_A;    ctl.ys = YS_ONES; ctl.kill = 1'b0; end
      OP_SHL:   begin ctl.xs = XS_A;    ctl.ys = YS_A;    ctl.kill = 1'b0; end
      OP_AND,
      OP_OR,
      OP_XOR:   begin ctl.xs = XS_A;    ctl.ys = YS_B;    ctl.kill = 1'b1; end
      OP_PASSA: begin ctl.xs = XS_A;    ctl.ys = YS_ZERO; ctl.kill = 1'b1; end
      OP_PASSB: begin ctl.xs = XS_ZERO; ctl.ys = YS_B;    ctl.kill = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain
  import alu_shared_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  adder_ctl_t   ctl,
  output logic [W-1:0] sum,
  output logic [W-1:0] gen,
  output logic [W-1:0] prp,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] x_in;
  logic [W-1:0] y_in;

  always_comb begin
    unique case (ctl.xs)
      XS_A:    x_in = a;
      XS_NA:   x_in = ~a;
      default: x_in = '0;
    endcase
    unique case (ctl.ys)
      YS_B:    y_in = b;
      YS_NB:   y_in = ~b;
      YS_ONES: y_in = '1;
      YS_A:    y_in = a;
      default: y_in = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i] = x_in[i] & y_in[i];
    assign prp[i] = x_in[i] ^ y_in[i];
  end

  always_comb begin
    logic c;
    c = ctl.cin & ~ctl.kill;
    for (int i = 0; i < W; i++) begin
      sum[i] = prp[i] ^ c;
      c      = ~ctl.kill & (gen[i] | (prp[i] & c));
    end
    cout = c;
  end

  assign ovf = ~ctl.kill & (x_in[W-1] == y_in[W-1]) & (sum[W-1] != x_in[W-1]);
endmodule

// File: rtl/alu_out_select.sv
module alu_out_select
  import alu_shared_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    sum,
  input  logic [W-1:0]    gen,
  input  logic [W-1:0]    prp,
  output logic [W-1:0]    res
);
  logic [W-1:0] cand [N_OPS];

  for (genvar k = 0; k < N_OPS; k++) begin : g_cand
    if (k == int'(OP_AND)) begin : g_and
      assign cand[k] = gen;
    end else if (k == int'(OP_OR)) begin : g_or
      assign cand[k] = gen | prp;
    end else if (k <= int'(OP_PASSB)) begin : g_sum
      assign cand[k] = sum;
    end else begin : g_zero
      assign cand[k] = '0;
    end
  end

  assign res = cand[op];
endmodule

// File: rtl/alu_shared.sv
module alu_shared
  import alu_shared_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             flag_carry,
  output logic             flag_zero,
  output logic             flag_ovf
);
  adder_ctl_t       ctl;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prp;

  alu_op_decode u_dec (
    .op  (op_sel),
    .ctl (ctl)
  );

  alu_carry_chain #(.W(WIDTH)) u_add (
    .a    (opnd_a),
    .b    (opnd_b),
    .ctl  (ctl),
    .sum  (sum),
    .gen  (gen),
    .prp  (prp),
    .cout (flag_carry),
    .ovf  (flag_ovf)
  );

  alu_out_select #(.W(WIDTH)) u_sel (
    .op  (op_sel),
    .sum (sum),
    .gen (gen),
    .prp (prp),
    .res (result)
  );

  assign flag_zero = ~|result;
endmodule

// File: rtl/alu_shared_chk.sv
module alu_shared_chk #(
  parameter int W = 16
) (
  input logic [3:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         flag_carry,
  input logic         flag_zero,
  input logic         flag_ovf
);
  always_comb begin
    assert_zero_flag_R10: assert (flag_zero == (result == '0))
      else $error("zero flag disagrees with result");
    if (op_sel >= 4'd12) begin
      assert_reserved_R9: assert (result == '0 && !flag_carry && !flag_ovf)
        else $error("reserved code produced output");
    end
    if (op_sel >= 4'd7 && op_sel <= 4'd9) begin
      assert_logic_flags_R7: assert (!flag_carry && !flag_ovf)
        else $error("logic code raised a flag");
    end
    if (op_sel == 4'd0) begin
      assert_add_sum_R1: assert (result == W'(opnd_a + opnd_b))
        else $error("add result wrong");
    end
    if (op_sel == 4'd1) begin
      assert_sub_carry_R2: assert (flag_carry == (opnd_a >= opnd_b))
        else $error("subtract carry wrong");
    end
    if (op_sel == 4'd6) begin
      assert_shl_carry_R6: assert (flag_carry == opnd_a[W-1])
        else $error("shift carry wrong");
    end
  end
endmodule

bind alu_shared alu_shared_chk #(.W(WIDTH)) u_chk (.*);

// File: tb/sim_alu_shared.sv
`timescale 1ns/1ps
module sim_alu_shared;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic [15:0] result;
  logic        flag_carry;
  logic        flag_zero;
  logic        flag_ovf;

  int n_checks;
  int n_fail;
  bit done;

  alu_shared u0 (
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .flag_ovf   (flag_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {op, a, b, result, carry, zero, ovf}
  localparam int NV = 18;
  localparam logic [54:0] VEC [NV] = '{
    {4'd0,  16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b0, 1'b1},  // R1 ovf
    {4'd0,  16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0},  // R1 carry+zero
    {4'd0,  16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b1},  // R1 all flags
    {4'd1,  16'h0005, 16'h0007, 16'hFFFE, 1'b0, 1'b0, 1'b0},  // R2 borrow
    {4'd1,  16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b0, 1'b1},  // R2 carry+ovf
    {4'd2,  16'h0001, 16'h1234, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R3
    {4'd2,  16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},  // R3 carry+zero
    {4'd2,  16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b1},  // R3 ovf
    {4'd3,  16'h00FF, 16'h0000, 16'hFF00, 1'b0, 1'b0, 1'b0},  // R4
    {4'd4,  16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},  // R5 inc wrap
    {4'd5,  16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R5 dec wrap
    {4'd6,  16'hC001, 16'h0000, 16'h8002, 1'b1, 1'b0, 1'b0},  // R6
    {4'd7,  16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 1'b0, 1'b0},  // R7 and
    {4'd8,  16'hF0F0, 16'h0F0F, 16'hFFFF, 1'b0, 1'b0, 1'b0},  // R7 or
    {4'd9,  16'hAAAA, 16'hAAAA, 16'h0000, 1'b0, 1'b1, 1'b0},  // R7 xor
    {4'd10, 16'h1234, 16'hFFFF, 16'h1234, 1'b0, 1'b0, 1'b0},  // R8 pass a
    {4'd11, 16'hFFFF, 16'h5678, 16'h5678, 1'b0, 1'b0, 1'b0},  // R8 pass b
    {4'd12, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0}   // R9 reserved
  };

  localparam logic [15:0] EDGE [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  // reference model built on wide integer arithmetic: {result, carry, zero, ovf}
  function automatic logic [18:0] ref_model(input logic [3:0] op, input logic [15:0] a,
                                            input logic [15:0] b);
    logic [16:0] wide;
    logic [15:0] r;
    logic        c;
    logic        v;
    c = 1'b0; v = 1'b0; r = 16'h0000;
    case (op)
      4'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[15:0]; c = wide[16];
                  v = (a[15] == b[15]) && (r[15] != a[15]); end
      4'd1: begin r = a - b; c = (a >= b); v = (a[15] != b[15]) && (r[15] != a[15]); end
      4'd2: begin r = 16'h0000 - a; c = (a == 16'h0000); v = (a == 16'h8000); end
      4'd3: r = ~a;
      4'd4: begin r = a + 16'h0001; c = (a == 16'hFFFF); v = (a == 16'h7FFF); end
      4'd5: begin r = a - 16'h0001; c = (a != 16'h0000); v = (a == 16'h8000); end
      4'd6: begin r = {a[14:0], 1'b0}; c = a[15]; v = a[15] ^ a[14]; end
      4'd7: r = a & b;
      4'd8: r = a | b;
      4'd9: r = a ^ b;
      4'd10: r = a;
      4'd11: r = b;
      default: r = 16'h0000;
    endcase
    return {r, c, (r == 16'h0000), v};
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                             input logic [18:0] exp, input string tag);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    #2;
    n_checks++;
    if ({result, flag_carry, flag_zero, flag_ovf} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h actual r=%h c=%b z=%b v=%b expected r=%h c=%b z=%b v=%b",
               tag, op, a, b, result, flag_carry, flag_zero, flag_ovf,
               exp[18:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8, 4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    logic [31:0] lfsr;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_sel = 4'd0; opnd_a = 16'h0000; opnd_b = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-state inputs: add of zeros gives zero result, zero flag only (R10)
    apply_check(4'd0, 16'h0000, 16'h0000, {16'h0000, 1'b0, 1'b1, 1'b0}, "R10 idle");

    // hand-computed vector table
    for (int i = 0; i < NV; i++) begin
      apply_check(VEC[i][54:51], VEC[i][50:35], VEC[i][34:19], VEC[i][18:0],
                  req_of(VEC[i][54:51]));
    end

    // every code over boundary operands; zero flag judged in every vector (R10)
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply_check(4'(op), EDGE[i], EDGE[j], ref_model(4'(op), EDGE[i], EDGE[j]),
                      req_of(4'(op)));
        end
      end
    end

    // pseudo-random operands per code
    lfsr = 32'hACE1_2468;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 40; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply_check(4'(op), lfsr[15:0], lfsr[31:16],
                    ref_model(4'(op), lfsr[15:0], lfsr[31:16]), req_of(4'(op)));
      end
    end

    // reserved codes ignore operands entirely (R9)
    for (int op = 12; op < 16; op++) begin
      apply_check(4'(op), 16'h8001, 16'h7FFE, {16'h0000, 1'b0, 1'b1, 1'b0}, "R9 ignore");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule